// File: doc/BRIEF.md
# Streaming Gradient Magnitude and Orientation Binner

This block takes a raster stream of 8-bit grey pixels and, for every pixel of the frame, produces an approximate gradient strength and an unsigned orientation bin. These two values feed a later histogram stage. Two line buffers hold the previous two image rows, so each pixel is seen inside its full 3x3 neighbourhood. A horizontal difference and a vertical difference are taken across the centre, and both are reduced with comparators, constant shifts and adders only. No square root, divider, arctangent or general multiplier appears anywhere in the datapath.

The output for centre pixel (r, c) is formed once input pixel (r+1, c+1) has arrived. Neighbours that fall outside the frame are replaced by the nearest pixel inside it. The last column of every line and the last row of every frame are finished in slots that the block generates itself. It does this in the idle cycles the source must leave after each line and after each frame. Frame geometry is fixed by parameters. The frame-start and line-start strobes keep the internal position counters aligned to the stream.

Top module: `grad_orient`

## Requirements
- R1: After reset `out_valid` is low, and it stays low until an input pixel of image row 1, column 1 or later has been accepted.
- R2: For centre (r, c) the horizontal gradient is P(r, c+1) - P(r, c-1) and the vertical gradient is P(r+1, c) - P(r-1, c). Any coordinate outside the frame is clamped to the nearest row or column inside it.
- R3: With a = max(|Gx|, |Gy|) and b = min(|Gx|, |Gy|), let m = a - floor(a/8) + floor(b/2). `out_mag` is the larger of a and m, as an integer, saturated at 255.
- R4: The bin edges use tangent constants T = 21, 46, 88 and 197 in units of 1/64. Let k count the constants for which 64*|Gy| > T*|Gx|. If Gx and Gy are both nonzero and have opposite signs, `out_bin` is 9-k; otherwise it is k. Bins are 18 degrees wide, bin 0 is horizontal and bin 4 holds vertical.
- R5: A neighbourhood with no horizontal or vertical difference gives `out_mag` = 0 and `out_bin` = 0.
- R6: Each frame yields exactly IMG_W*IMG_H outputs in raster order. `out_row` and `out_col` count from 0, and `out_col` steps by one between consecutive outputs on the same row.
- R7: The output for an interior centre (r, c) appears on the outputs three clock cycles after the rising edge that accepts input pixel (r+1, c+1).
- R8: The source leaves at least one idle cycle after the last pixel of each line. After the last pixel of a frame it leaves at least IMG_W+2 idle cycles. The right-column and bottom-row outputs are generated in those cycles.
- R9: A pixel with the frame-start strobe restarts numbering at (0, 0). A new frame may begin right after the minimum idle gap, and its top row uses only its own pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Input pixel present this cycle |
| pix_sol | input | 1 | Pixel is the first of a line |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_data | input | 8 | Grey level |
| out_valid | output | 1 | Output result present |
| out_mag | output | 8 | Approximate gradient magnitude |
| out_bin | output | 4 | Orientation bin, 0 to 9 |
| out_row | output | RW | Row of the centre pixel |
| out_col | output | CW | Column of the centre pixel |

## Verification
Two things can land in the same cycle. The pipeline may still be emitting the bottom row of one frame from its self-generated flush slots while the first pixels of the next frame enter the line buffers. The bench provokes this by starting a frame after exactly the minimum idle gap. It holds the two frames in separate image buffers and compares every output against the frame its coordinates belong to. A right-border synthetic slot likewise directly follows each line end, and lines are packed with only one idle cycle so that the slot meets the next line's first pixel back to back.

// File: rtl/grad_pkg.sv
package grad_pkg;
  localparam int PIX_W    = 8;
  localparam int N_BINS   = 10;
  localparam int BIN_W    = $clog2(N_BINS);
  localparam int N_EDGES  = N_BINS / 2 - 1;
  localparam int TAN_FRAC = 6;
  localparam int TAN_W    = 8;
  // tangent of each in-quadrant bin edge, scaled by 2**TAN_FRAC (edge 0 lowest)
  localparam logic [N_EDGES*TAN_W-1:0] TAN_Q = {8'd197, 8'd88, 8'd46, 8'd21};

  typedef struct packed {
    logic [PIX_W-1:0] top;
    logic [PIX_W-1:0] mid;
    logic [PIX_W-1:0] bot;
  } col_t;
endpackage

// File: rtl/gm_line_store.sv
module gm_line_store
  import grad_pkg::*;
#(
  parameter int DEPTH = 640,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             near_we,
  input  logic [PIX_W-1:0] near_wdata,
  output logic [PIX_W-1:0] near_rdata,
  input  logic             far_we,
  input  logic [AW-1:0]    far_waddr,
  input  logic [PIX_W-1:0] far_wdata,
  output logic [PIX_W-1:0] far_rdata
);
  // near line: newest complete row, read-first on a shared address
  logic [PIX_W-1:0] near_mem [DEPTH];
  // far line: the row before that, simple dual port
  logic [PIX_W-1:0] far_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (rd_en) begin
      if (near_we) near_mem[rd_addr] <= near_wdata;
      near_rdata <= near_mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (far_we) far_mem[far_waddr] <= far_wdata;
    if (rd_en)  far_rdata <= far_mem[rd_addr];
  end
endmodule

// File: rtl/gm_window.sv
module gm_window
  import grad_pkg::*;
(
  input  logic             clk,
  input  logic             shift,
  input  logic             hold_col,
  input  logic             top_rep,
  input  logic             bot_rep,
  input  logic [PIX_W-1:0] near_px,
  input  logic [PIX_W-1:0] far_px,
  input  logic [PIX_W-1:0] new_px,
  output col_t             w_left,
  output col_t             w_mid,
  output col_t             w_right
);
  localparam int TAPS = 3;
  col_t taps [TAPS];
  col_t fresh;

  always_comb begin
    if (hold_col) begin
      fresh = taps[TAPS-1];
    end else begin
      fresh.mid = near_px;
      fresh.top = top_rep ? near_px : far_px;
      fresh.bot = bot_rep ? near_px : new_px;
    end
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (shift) taps[i] <= (i == TAPS-1) ? fresh : taps[(i+1) % TAPS];
    end
  end

  assign w_left  = taps[0];
  assign w_mid   = taps[1];
  assign w_right = taps[2];
endmodule

// File: rtl/gm_grad_core.sv
module gm_grad_core
  import grad_pkg::*;
#(
  parameter int RW = 9,
  parameter int CW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             left_rep,
  input  logic [RW-1:0]    in_row,
  input  logic [CW-1:0]    in_col,
  input  col_t             w_left,
  input  col_t             w_mid,
  input  col_t             w_right,
  output logic             o_valid,
  output logic [PIX_W-1:0] o_mag,
  output logic [BIN_W-1:0] o_bin,
  output logic [RW-1:0]    o_row,
  output logic [CW-1:0]    o_col
);
  localparam int GW      = PIX_W + 1;
  localparam int MW      = PIX_W + 2;
  localparam int PROD_W  = PIX_W + TAN_W + 1;
  localparam int MAG_MAX = (1 << PIX_W) - 1;

  function automatic logic [PROD_W-1:0] shift_add(input logic [PIX_W-1:0] x,
                                                  input logic [TAN_W-1:0] k);
    logic [PROD_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < TAN_W; i++)
      if (k[i]) acc = acc + (PROD_W'(x) << i);
    return acc;
  endfunction

  // stage A: central differences and their absolute values
  logic [PIX_W-1:0] left_px;
  logic [GW-1:0]    gx, gy, ngx, ngy;
  always_comb begin
    left_px = left_rep ? w_mid.mid : w_left.mid;
    gx  = {1'b0, w_right.mid} - {1'b0, left_px};
    gy  = {1'b0, w_mid.bot}   - {1'b0, w_mid.top};
    ngx = -gx;
    ngy = -gy;
  end

  logic             va, q2;
  logic [PIX_W-1:0] ax, ay;
  logic [RW-1:0]    ra;
  logic [CW-1:0]    ca;
  always_ff @(posedge clk) begin
    if (rst) va <= 1'b0;
    else     va <= in_valid;
    ax <= gx[GW-1] ? ngx[PIX_W-1:0] : gx[PIX_W-1:0];
    ay <= gy[GW-1] ? ngy[PIX_W-1:0] : gy[PIX_W-1:0];
    q2 <= (gx != '0) && (gy != '0) && (gx[GW-1] ^ gy[GW-1]);
    ra <= in_row;
    ca <= in_col;
  end

  // stage B: max/min magnitude and tangent-edge comparison
  logic [PIX_W-1:0] a, b, mag;
  logic [MW-1:0]    approx, best;
  always_comb begin
    a      = (ax >= ay) ? ax : ay;
    b      = (ax >= ay) ? ay : ax;
    approx = MW'(a) - MW'(a >> 3) + MW'(b >> 1);
    best   = (approx > MW'(a)) ? approx : MW'(a);
    mag    = (best > MW'(MAG_MAX)) ? PIX_W'(MAG_MAX) : best[PIX_W-1:0];
  end

  logic [PROD_W-1:0]  gy_sc;
  logic [N_EDGES-1:0] above;
  assign gy_sc = PROD_W'(ay) << TAN_FRAC;

  for (genvar j = 0; j < N_EDGES; j++) begin : g_edge
    logic [PROD_W-1:0] thr;
    assign thr      = shift_add(ax, TAN_Q[j*TAN_W +: TAN_W]);
    assign above[j] = gy_sc > thr;
  end

  logic [BIN_W-1:0] k, bin;
  always_comb begin
    k   = BIN_W'($countones(above));
    bin = q2 ? (BIN_W'(N_BINS - 1) - k) : k;
  end

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else     o_valid <= va;
    o_mag <= mag;
    o_bin <= bin;
    o_row <= ra;
    o_col <= ca;
  end

  a_r3_mag_floor: assert property (@(posedge clk) disable iff (rst)
    va |=> (o_mag >= $past(ax)) && (o_mag >= $past(ay)));

  a_r5_flat_zero: assert property (@(posedge clk) disable iff (rst)
    (va && ax == '0 && ay == '0) |=> (o_mag == '0) && (o_bin == '0));

  a_r4_bin_range: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_bin < BIN_W'(N_BINS)));
endmodule

// File: rtl/grad_orient.sv
module grad_orient
  import grad_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  localparam int AW = $clog2(IMG_W),
  localparam int CW = $clog2(IMG_W + 1),
  localparam int RW = $clog2(IMG_H + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic             pix_sol,
  input  logic             pix_sof,
  input  logic [PIX_W-1:0] pix_data,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_mag,
  output logic [BIN_W-1:0] out_bin,
  output logic [RW-1:0]    out_row,
  output logic [CW-1:0]    out_col
);
  localparam logic [CW-1:0] LAST_COL = CW'(IMG_W - 1);
  localparam logic [CW-1:0] PAD_COL  = CW'(IMG_W);
  localparam logic [RW-1:0] LAST_ROW = RW'(IMG_H - 1);
  localparam logic [RW-1:0] PAD_ROW  = RW'(IMG_H);

  // stage 0: slot generation (real pixels, right pad slot, bottom pad row)
  logic [RW-1:0] row_q, colp_row, s_r;
  logic [CW-1:0] col_q, fcol, s_c;
  logic          colp, flush, s_v, s_real;

  always_comb begin
    s_v    = 1'b0;
    s_real = 1'b0;
    s_r    = row_q;
    s_c    = col_q;
    if (pix_valid) begin
      s_v    = 1'b1;
      s_real = 1'b1;
      if (pix_sof) begin
        s_r = '0;
        s_c = '0;
      end else if (pix_sol) begin
        s_r = row_q + 1'b1;
        s_c = '0;
      end else begin
        s_c = col_q + 1'b1;
      end
    end else if (colp) begin
      s_v = 1'b1;
      s_r = colp_row;
      s_c = PAD_COL;
    end else if (flush) begin
      s_v = 1'b1;
      s_r = PAD_ROW;
      s_c = fcol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q    <= '0;
      col_q    <= '0;
      colp     <= 1'b0;
      colp_row <= '0;
      flush    <= 1'b0;
      fcol     <= '0;
    end else begin
      if (pix_valid) begin
        row_q <= s_r;
        col_q <= s_c;
      end
      colp <= pix_valid && (s_c == LAST_COL);
      if (pix_valid && (s_c == LAST_COL)) colp_row <= s_r;
      if (!pix_valid && colp && (colp_row == LAST_ROW)) begin
        flush <= 1'b1;
        fcol  <= '0;
      end else if (!pix_valid && !colp && flush) begin
        if (fcol == PAD_COL) flush <= 1'b0;
        else                 fcol  <= fcol + 1'b1;
      end
    end
  end

  // line buffers
  logic             rd_en;
  logic [PIX_W-1:0] near_rd, far_rd;
  logic             v1, real1;
  logic [RW-1:0]    r1;
  logic [CW-1:0]    c1;
  logic [PIX_W-1:0] pix1;

  assign rd_en = s_v && (s_c != PAD_COL);

  gm_line_store #(.DEPTH(IMG_W)) u_lines (
    .clk        (clk),
    .rd_en      (rd_en),
    .rd_addr    (s_c[AW-1:0]),
    .near_we    (s_real),
    .near_wdata (pix_data),
    .near_rdata (near_rd),
    .far_we     (v1 && real1),
    .far_waddr  (c1[AW-1:0]),
    .far_wdata  (near_rd),
    .far_rdata  (far_rd)
  );

  // stage 1 tag
  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= s_v;
    real1 <= s_real;
    r1    <= s_r;
    c1    <= s_c;
    pix1  <= pix_data;
  end

  // 3x3 window
  col_t w_left, w_mid, w_right;
  gm_window u_win (
    .clk      (clk),
    .shift    (v1),
    .hold_col (c1 == PAD_COL),
    .top_rep  (r1 == RW'(1)),
    .bot_rep  (r1 == PAD_ROW),
    .near_px  (near_rd),
    .far_px   (far_rd),
    .new_px   (pix1),
    .w_left   (w_left),
    .w_mid    (w_mid),
    .w_right  (w_right)
  );

  // stage 2 tag: centre sits one row up and one column left of the slot
  logic          v2, lrep2;
  logic [RW-1:0] r2;
  logic [CW-1:0] c2;
  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1 && (r1 != '0) && (c1 != '0);
    lrep2 <= (c1 == CW'(1));
    r2    <= r1 - 1'b1;
    c2    <= c1 - 1'b1;
  end

  gm_grad_core #(.RW(RW), .CW(CW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .in_valid (v2),
    .left_rep (lrep2),
    .in_row   (r2),
    .in_col   (c2),
    .w_left   (w_left),
    .w_mid    (w_mid),
    .w_right  (w_right),
    .o_valid  (out_valid),
    .o_mag    (out_mag),
    .o_bin    (out_bin),
    .o_row    (out_row),
    .o_col    (out_col)
  );

  a_r6_col_step: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && (out_row == $past(out_row)))
      |-> (out_col == $past(out_col) + 1'b1));

  a_r8_idle_gap: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> !(colp || flush));
endmodule

// File: tb/grad_orient_bench.sv
`timescale 1ns/1ps
module grad_orient_bench;
  localparam int W  = 12;
  localparam int H  = 6;
  localparam int RW = $clog2(H + 1);
  localparam int CW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_valid = 1'b0, pix_sol = 1'b0, pix_sof = 1'b0;
  logic [7:0] pix_data = '0;
  logic out_valid;
  logic [7:0] out_mag;
  logic [3:0] out_bin;
  logic [RW-1:0] out_row;
  logic [CW-1:0] out_col;

  always #2 clk = ~clk;

  grad_orient #(.IMG_W(W), .IMG_H(H)) u_grad_orient (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sol(pix_sol),
    .pix_sof(pix_sof), .pix_data(pix_data), .out_valid(out_valid),
    .out_mag(out_mag), .out_bin(out_bin), .out_row(out_row), .out_col(out_col)
  );

  int total = 0, bad = 0, cyc = 0;
  int img [2][H][W];
  string tag_buf [2];
  int lat_cyc [2];
  int seen = 0, n_out = 0, er = 0, ec = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int px(int s, int r, int c);
    int rr = (r < 0) ? 0 : ((r > H-1) ? H-1 : r);
    int cc = (c < 0) ? 0 : ((c > W-1) ? W-1 : c);
    return img[s][rr][cc];
  endfunction

  // R2 gradients, R3 magnitude, R4 bin
  task automatic model(input int s, input int r, input int c,
                       output int m, output int bn);
    int gx, gy, ax, ay, a, b, t, k;
    int tq [4] = '{21, 46, 88, 197};
    bit q2;
    gx = px(s, r, c+1) - px(s, r, c-1);
    gy = px(s, r+1, c) - px(s, r-1, c);
    ax = (gx < 0) ? -gx : gx;
    ay = (gy < 0) ? -gy : gy;
    a = (ax >= ay) ? ax : ay;
    b = (ax >= ay) ? ay : ax;
    t = a - (a >> 3) + (b >> 1);
    if (t < a) t = a;
    if (t > 255) t = 255;
    k = 0;
    for (int j = 0; j < 4; j++) if (ay * 64 > ax * tq[j]) k++;
    q2 = (gx != 0) && (gy != 0) && ((gx < 0) != (gy < 0));
    m = t;
    bn = q2 ? 9 - k : k;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      int s, m, bn;
      if (out_row == 0 && out_col == 0) begin
        seen++;
        check(cyc == lat_cyc[(seen-1) % 2] + 4, "R7", "latency cycle",
              cyc, lat_cyc[(seen-1) % 2] + 4);
      end
      s = (seen - 1) % 2;
      check(out_row == er && out_col == ec, "R6", "coordinate",
            out_row * 100 + out_col, er * 100 + ec);
      model(s, er, ec, m, bn);
      check(out_mag == m, "R3", {tag_buf[s], " magnitude"}, out_mag, m);
      check(out_bin == bn, "R4", {tag_buf[s], " bin"}, out_bin, bn);
      n_out++;
      ec++;
      if (ec == W) begin ec = 0; er++; end
      if (er == H) er = 0;
    end
  end

  task automatic idle(input int n);
    pix_valid = 1'b0; pix_sol = 1'b0; pix_sof = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int f, input int gap_pct, input int tail);
    int s = f % 2;
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        pix_valid = 1'b1;
        pix_sof   = (r == 0 && c == 0);
        pix_sol   = (c == 0);
        pix_data  = 8'(img[s][r][c]);
        if (r == 1 && c == 1) lat_cyc[s] = cyc;
        @(negedge clk);
        pix_valid = 1'b0; pix_sof = 1'b0; pix_sol = 1'b0;
        if (c < W-1 && ($urandom % 100) < gap_pct) idle(1 + $urandom % 2);
      end
      if (r < H-1) idle((gap_pct == 0) ? 1 : 1 + $urandom % 2);
    end
    idle(tail);
  endtask

  // kind: 0 flat, 1 hramp, 2 vramp, 3 diagonal step, 4 binary random, 5 random
  task automatic fill(input int f, input int kind, input string tag);
    int s = f % 2;
    tag_buf[s] = tag;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        case (kind)
          0: img[s][r][c] = 100;
          1: img[s][r][c] = c * 20;
          2: img[s][r][c] = r * 40;
          3: img[s][r][c] = (r + c >= 7) ? 255 : 0;
          4: img[s][r][c] = ($urandom % 2) ? 255 : 0;
          default: img[s][r][c] = $urandom % 256;
        endcase
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
    idle(5);
    check(out_valid == 1'b0, "R1", "valid before data", out_valid, 0);

    fill(0, 0, "R5 flat");          send_frame(0, 0, W + 8);
    fill(1, 1, "R2 hramp");         send_frame(1, 0, W + 8);
    fill(2, 2, "R2 vramp");         send_frame(2, 0, W + 8);
    fill(3, 3, "R3 saturating");    send_frame(3, 0, W + 8);
    fill(4, 4, "R3 binary");        send_frame(4, 20, W + 8);
    for (int f = 5; f < 9; f++) begin
      fill(f, 5, "R8 gapped");      send_frame(f, 30, W + 8);
    end
    // R9: frames back to back at the minimum gap
    for (int f = 9; f < 13; f++) begin
      fill(f, 5, "R9 packed");      send_frame(f, 0, W + 2);
    end
    idle(W + 10);
    check(n_out == 13 * W * H, "R6", "output count", n_out, 13 * W * H);
    check(seen == 13, "R9", "frames restarted", seen, 13);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule